// File: doc/BRIEF.md
# Cascade-Aligning Output Sum Conditioner

This block sits after the adder tree of a multi-tap filter slice. It accepts the wide, untruncated sum. It keeps only the most significant bits of that sum and feeds the shortened value into a delay line whose length is chosen at run time. The delay lets partial sums from several chained filter slices arrive at a downstream cascade adder in the same clock. That adder lies outside this block.

Each sample carries two control flags, a clear flag and an invert flag. Both flags ride through the same delay stages as the data, so they stay attached to the sample they were issued with. The block applies them only at the tap output. The clear flag forces the result to zero. The invert flag turns the result into its two's-complement negation. Negating the most negative value saturates.

Top module: `cascade_sum_cond`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every delay stage is cleared, so `sum_out` reads 0 in the following cycle whatever `dly_sel` is.
- R2: The value carried forward is bits [SUM_W-1 : SUM_W-OUT_W] of `sum_in`, the top 16 of 24 by default. The lower bits are discarded with no rounding and have no effect on `sum_out`.
- R3: A sample presented before rising edge k appears on `sum_out` after edge k+`dly_sel`. It therefore passes through `dly_sel`+1 register stages.
- R4: With `dly_sel` = 0 the path has exactly one register stage, and an unflagged sample appears one cycle after it is presented.
- R5: `clear_in` and `invert_in` are delayed by the same number of stages as the sum they accompany, and they act on that sample only.
- R6: When the delayed clear flag is 1, `sum_out` is 0.
- R7: When the delayed invert flag is 1 and the clear flag is 0, `sum_out` is the two's-complement negation of the truncated sample.
- R8: When both delayed flags are 1, clear wins and `sum_out` is 0.
- R9: Inverting the most negative truncated value (0x8000 for 16 bits) yields the largest positive value (0x7FFF).
- R10: The largest setting, `dly_sel` = 7, gives eight register stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sum_in | input | SUM_W (24) | Untruncated adder-tree sum, two's complement |
| clear_in | input | 1 | Per-sample flag: force this sample's result to zero |
| invert_in | input | 1 | Per-sample flag: negate this sample's result |
| dly_sel | input | DLY_W (3) | Extra delay stages beyond the first, 0 to 7 |
| sum_out | output | OUT_W (16) | Conditioned, aligned sum |

## Verification
A sample and its flags, driven before edge k, are due on `sum_out` in the cycle after edge k+`dly_sel`. The conditioning stage is combinational behind the selected tap, so no further cycle is added. The driver stamps every expected item with that due cycle. The monitor samples at the falling edge and compares only the entry whose stamp matches the current cycle count. An entry that has gone past its stamp is counted as a failure. `dly_sel` is changed only after the queue has drained, so the combinational tap select never moves under a pending result.

// File: rtl/cascade_sum_cond_pkg.sv
// Package: shared decode for the sum conditioner.
// Assumes: flags are active high; clear outranks invert.
package cascade_sum_cond_pkg;

    typedef enum logic [1:0] {
        ACT_PASS  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_NEG   = 2'd2
    } cond_act_e;

    // Map the two delayed flags onto a single action, clear first (R8).
    function automatic cond_act_e decode_act(input logic clr, input logic inv);
        if (clr)
            return ACT_CLEAR;
        else if (inv)
            return ACT_NEG;
        else
            return ACT_PASS;
    endfunction

endpackage

// File: rtl/sum_trunc.sv
// Module: sum_trunc
// Keeps the OUT_W most significant bits of a SUM_W-bit sum and drops the
// rest without rounding. Assumes SUM_W >= OUT_W.
module sum_trunc #(
    parameter int SUM_W = 24,
    parameter int OUT_W = 16
) (
    input  logic [SUM_W-1:0] wide_sum,
    output logic [OUT_W-1:0] narrow_sum
);

    localparam int DROP_W = SUM_W - OUT_W;

    // Slice off the upper bits (R2).
    always_comb narrow_sum = wide_sum[SUM_W-1 -: OUT_W];

    generate
        if (DROP_W > 0) begin : g_drop
            logic unused_low_bits;
            // Discarded fraction bits are intentionally left unused.
            always_comb unused_low_bits = ^wide_sum[DROP_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/tap_delay.sv
// Module: tap_delay
// Shift line of 2**DLY_W registers that always advances; the output is the
// stage chosen by sel, so sel = 0 gives one register stage. Synchronous
// active-low reset clears every stage. Assumes sel is held steady while
// results are being consumed.
module tap_delay #(
    parameter int W     = 18,
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     d_in,
    input  logic [DLY_W-1:0] sel,
    output logic [W-1:0]     d_out
);

    localparam int NSTG = 1 << DLY_W;

    logic [W-1:0] stg [NSTG];

    // First stage captures the incoming word (R3, R4).
    always_ff @(posedge clk) begin
        if (!rst_n)
            stg[0] <= '0;
        else
            stg[0] <= d_in;
    end

    generate
        for (genvar i = 1; i < NSTG; i++) begin : g_stage
            // Each later stage copies its predecessor every cycle (R3, R10).
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stg[i] <= '0;
                else
                    stg[i] <= stg[i-1];
            end
        end
    endgenerate

    // Select the programmed tap.
    always_comb d_out = stg[sel];

endmodule

// File: rtl/sum_apply.sv
// Module: sum_apply
// Applies the delayed clear / invert flags to the delayed sample. Negation of
// the most negative value saturates to the largest positive value.
// Combinational; clk and rst_n only clock the local checks.
module sum_apply #(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OUT_W-1:0] val,
    input  logic             clr,
    input  logic             inv,
    output logic [OUT_W-1:0] res
);
    import cascade_sum_cond_pkg::*;

    localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};
    localparam logic [OUT_W-1:0] MOST_POS = {1'b0, {(OUT_W-1){1'b1}}};

    cond_act_e act;

    // Resolve flag priority.
    always_comb act = decode_act(clr, inv);

    // Produce the conditioned result (R6, R7, R9).
    always_comb begin
        unique case (act)
            ACT_CLEAR: res = '0;
            ACT_NEG:   res = (val == MOST_NEG) ? MOST_POS : (~val + 1'b1);
            default:   res = val;
        endcase
    end

    // R6
    clear_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> res == '0);

    // R7
    neg_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv && !clr && val != MOST_NEG) |-> (res + val) == '0);

    // R8
    clear_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inv) |-> res == '0);

    // R9
    neg_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv && !clr && val == MOST_NEG) |-> res == MOST_POS);

endmodule

// File: rtl/cascade_sum_cond.sv
// Module: cascade_sum_cond (top)
// Truncates the adder-tree sum, delays it together with its clear / invert
// flags by dly_sel+1 cycles, then applies the flags at the tap output.
// Assumes dly_sel is static while aligned results are needed.
module cascade_sum_cond #(
    parameter int SUM_W = 24,
    parameter int OUT_W = 16,
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] sum_in,
    input  logic             clear_in,
    input  logic             invert_in,
    input  logic [DLY_W-1:0] dly_sel,
    output logic [OUT_W-1:0] sum_out
);

    localparam int LINE_W = OUT_W + 2;

    logic [OUT_W-1:0]  trunc_val;
    logic [LINE_W-1:0] line_in;
    logic [LINE_W-1:0] line_out;

    sum_trunc #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_trunc (
        .wide_sum   (sum_in),
        .narrow_sum (trunc_val)
    );

    // Bundle the flags with the sample so they travel together (R5).
    always_comb line_in = {clear_in, invert_in, trunc_val};

    tap_delay #(.W(LINE_W), .DLY_W(DLY_W)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (line_in),
        .sel   (dly_sel),
        .d_out (line_out)
    );

    sum_apply #(.OUT_W(OUT_W)) u_apply (
        .clk   (clk),
        .rst_n (rst_n),
        .val   (line_out[OUT_W-1:0]),
        .clr   (line_out[OUT_W+1]),
        .inv   (line_out[OUT_W]),
        .res   (sum_out)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> sum_out == '0);

    // R4 (also R2: only the top bits reach the output)
    trunc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && dly_sel == '0 && $past(dly_sel) == '0
         && !$past(clear_in) && !$past(invert_in))
        |-> sum_out == $past(sum_in[SUM_W-1 -: OUT_W]));

endmodule

// File: tb/cascade_sum_cond_bench.sv
module cascade_sum_cond_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SUM_W = 24;
    localparam int OUT_W = 16;
    localparam int DLY_W = 3;

    typedef struct {
        logic [OUT_W-1:0] val;
        int               due;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [SUM_W-1:0] sum_in = '0;
    logic             clear_in = 1'b0;
    logic             invert_in = 1'b0;
    logic [DLY_W-1:0] dly_sel = '0;
    logic [OUT_W-1:0] sum_out;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;
    exp_t q[$];

    cascade_sum_cond #(.SUM_W(SUM_W), .OUT_W(OUT_W), .DLY_W(DLY_W)) u_cascade_sum_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .sum_in    (sum_in),
        .clear_in  (clear_in),
        .invert_in (invert_in),
        .dly_sel   (dly_sel),
        .sum_out   (sum_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Expected result from the requirements: top bits, clear first, saturating negate.
    function automatic logic [OUT_W-1:0] model(input logic [SUM_W-1:0] s,
                                               input logic c, input logic n);
        logic [OUT_W-1:0] t;
        t = s[SUM_W-1 -: OUT_W];
        if (c) return '0;
        if (n) return (t == 16'h8000) ? 16'h7FFF : (16'h0 - t);
        return t;
    endfunction

    task automatic check(input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp_v,
                         input string tag);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp_v, cyc);
        end
    endtask

    // Driver: present one sample and push its expected result with its due cycle.
    task automatic drive(input logic [SUM_W-1:0] s, input logic c, input logic n,
                         input string tag);
        exp_t e;
        @(negedge clk);
        #1;
        sum_in = s; clear_in = c; invert_in = n;
        e.val = model(s, c, n);
        e.due = cyc + 1 + int'(dly_sel);
        e.tag = tag;
        q.push_back(e);
    endtask

    // Stop pushing and wait until every pending result has been compared.
    task automatic drain();
        @(negedge clk);
        #1;
        sum_in = '0; clear_in = 1'b0; invert_in = 1'b0;
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_delay(input int d);
        drain();
        #1;
        dly_sel = DLY_W'(d);
    endtask

    // Monitor: compare the head of the queue when its cycle is due.
    always @(negedge clk) begin
        if (mon_on) begin
            while (q.size() > 0 && q[0].due < cyc) begin
                n_chk++;
                n_fail++;
                $display("FAIL %s: actual missed expected %h due %0d", q[0].tag, q[0].val, q[0].due);
                void'(q.pop_front());
            end
            if (q.size() > 0 && q[0].due == cyc) begin
                check(sum_out, q[0].val, q[0].tag);
                void'(q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset clears the line, whatever the input and tap.
        sum_in = 24'h7F_FFFF; clear_in = 1'b0; invert_in = 1'b0; dly_sel = 3'd5;
        repeat (3) @(negedge clk);
        check(sum_out, 16'h0000, "R1");
        dly_sel = 3'd0;
        #1;
        check(sum_out, 16'h0000, "R1");
        @(negedge clk);
        #1;
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R2 R4: one stage, low bits dropped without rounding.
        drive(24'h12_34FF, 1'b0, 1'b0, "R2");
        drive(24'h12_3400, 1'b0, 1'b0, "R2");
        drive(24'hFF_FF80, 1'b0, 1'b0, "R4");
        drive(24'h80_0000, 1'b0, 1'b0, "R4");
        drive(24'h7F_FFFF, 1'b0, 1'b0, "R4");

        // R3 R5 R6 R7: three extra stages with mixed flags.
        set_delay(3);
        drive(24'h00_1234, 1'b0, 1'b0, "R3");
        drive(24'h01_0055, 1'b0, 1'b1, "R7");
        drive(24'hAB_CD12, 1'b1, 1'b0, "R6");
        drive(24'h05_5500, 1'b0, 1'b0, "R5");
        drive(24'hFF_FFFF, 1'b0, 1'b1, "R7");
        drive(24'h33_3300, 1'b0, 1'b0, "R5");

        // R8 R9: priority and saturation.
        set_delay(1);
        drive(24'h40_0000, 1'b1, 1'b1, "R8");
        drive(24'h80_0000, 1'b0, 1'b1, "R9");
        drive(24'h80_00FF, 1'b0, 1'b1, "R9");
        drive(24'h7F_FF00, 1'b0, 1'b1, "R7");

        // R10: longest line.
        set_delay(7);
        for (int i = 0; i < 10; i++)
            drive(24'(i * 24'h01_1111 + 24'h0000A5), (i % 4) == 3, (i % 3) == 1, "R10");
        drain();

        finish_run();
    end

endmodule